// File: doc/BRIEF.md
# Byte-Register Bank Target on a Two-Wire Serial Bus

This block lets an external bus master reach a small bank of 8-bit registers over the standard I2C two-wire bus (7-bit addressing). The block runs on a fast system clock, oversamples SCL and SDA, finds START and STOP conditions, matches its own device address and drives SDA low through an open-drain enable for acknowledges and read data.

A write transfer carries a sub-address byte first. That byte loads the byte pointer, and every data byte after it goes to the register at the pointer. Reads come in three forms. A current-address read returns the register at the pointer with no sub-address phase. A random-address read writes a sub-address and then issues a repeated START with the read bit set. A sequential read keeps returning consecutive registers for as long as the master acknowledges. One pointer serves both directions and steps forward after each data byte. Each register is either read-only or writable, and has a reset value or none. Software elsewhere on the chip sees the whole bank on a flat output bus.

Top module: `i2c_regbank_target`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR (default 0x2A) gets an ACK, meaning SDA is driven low in the ninth clock. Any other address gets a NACK. The block then ignores the transfer until the next START: no register and no pointer changes, and SDA stays released.
- R2: In a write transfer (address byte LSB = 0), the first byte after the address loads the pointer. Each following byte is written to the register at the pointer. Every byte is acknowledged.
- R3: The pointer advances by one after each data byte, whether written or read. Past address NUM_REGS-1, or from any value beyond it, the pointer goes to 0.
- R4: A read transfer (address byte LSB = 1) starts with no sub-address phase. It returns the register at the current pointer, MSB first, one bit per SCL clock.
- R5: A sub-address write followed by a repeated START and a read address returns the register named by that sub-address.
- R6: While the master ACKs each returned byte, the block keeps sending consecutive registers. After a master NACK it releases SDA and sends nothing more. After a STOP, SDA is released.
- R7: A write to a read-only register (default: registers 0 and 1) is acknowledged but leaves the register unchanged. The pointer still advances.
- R8: At reset, each register flagged in RST_MASK takes its value from RST_VAL. Defaults: reg0=0xAC, reg1=0x0C, reg2=0x21, reg3=0x33, reg4=0x44, reg5=0x55, reg7=0x77. reg6 has no reset value. The pointer resets to 0.
- R9: A pointer at or above NUM_REGS reads as 0x00. A write there is acknowledged and discarded.
- R10: A START or STOP at any point aborts the byte in progress. The partial byte is discarded and the bit count restarts.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| regs_o | output | NUM_REGS*8 | Register bank contents, register i at bits [8i+7:8i] |

## Verification
Each reaction by the block follows an SCL edge after two synchronizer stages, one edge-detect register and one state register. So SDA drive moves about four system clocks after the SCL fall that causes it. The bench waits six system clocks in every quarter of an SCL bit and samples SDA in the middle of the SCL high phase, well after that latency and well before the next edge. A register write lands in the cycle that follows the SCL fall closing the eighth data bit. The bench reads regs_o only after the STOP, many cycles later, and checks the pointer by reading back through the bus.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WR,
        ST_RD,
        ST_SKIP
    } bus_st_e;

    typedef struct packed {
        bus_st_e     st;
        logic [3:0]  bitcnt;
        logic        ack_slot;
        logic [7:0]  shreg;
        logic [7:0]  tx;
        logic [7:0]  ptr;
        logic        rw;
        logic        first;
        logic        mack;
        logic        oe;
    } fsm_t;

endpackage

// File: rtl/i2c_rb_lines.sv
module i2c_rb_lines #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl_o,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sh_d, scl_sh_q, sda_sh_d, sda_sh_q;
    logic         scl_prev_d, scl_prev_q, sda_prev_d, sda_prev_q;
    logic         scl_now, sda_now;

    always_comb begin
        scl_sh_d   = {scl_sh_q[TOP-1:0], scl_i};
        sda_sh_d   = {sda_sh_q[TOP-1:0], sda_i};
        scl_now    = scl_sh_q[TOP];
        sda_now    = sda_sh_q[TOP];
        scl_prev_d = scl_now;
        sda_prev_d = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q   <= '1;
            sda_sh_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sh_q   <= scl_sh_d;
            sda_sh_q   <= sda_sh_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_lvl_o  = scl_now;
    assign sda_lvl_o  = sda_now;
    assign scl_rise_o = scl_now & ~scl_prev_q;
    assign scl_fall_o = ~scl_now & scl_prev_q;
    assign start_o    = scl_now & scl_prev_q & sda_prev_q & ~sda_now;
    assign stop_o     = scl_now & scl_prev_q & ~sda_prev_q & sda_now;

endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         NUM_REGS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_lvl_i,
    input  logic       sda_lvl_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic [7:0] rdata_i,
    output logic [7:0] ptr_o,
    output logic       we_o,
    output logic [7:0] wdata_o,
    output logic       sda_oe_o
);
    localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

    fsm_t q, d;
    logic adv;

    function automatic logic [7:0] next_ptr(input logic [7:0] p);
        return (p >= LAST) ? 8'd0 : p + 8'd1;
    endfunction

    always_comb begin
        d       = q;
        we_o    = 1'b0;
        wdata_o = q.shreg;
        adv     = 1'b0;
        if (start_i) begin
            d.st       = ST_ADDR;
            d.bitcnt   = 4'd0;
            d.ack_slot = 1'b0;
            d.oe       = 1'b0;
        end else if (stop_i) begin
            d.st       = ST_IDLE;
            d.bitcnt   = 4'd0;
            d.ack_slot = 1'b0;
            d.oe       = 1'b0;
        end else if (q.st == ST_ADDR || q.st == ST_WR || q.st == ST_RD) begin
            if (scl_rise_i) begin
                if (!q.ack_slot) begin
                    d.shreg  = {q.shreg[6:0], sda_lvl_i};
                    d.bitcnt = q.bitcnt + 4'd1;
                end else if (q.st == ST_RD) begin
                    d.mack = ~sda_lvl_i;
                end
            end else if (scl_fall_i) begin
                if (!q.ack_slot && q.bitcnt == 4'd8) begin
                    d.ack_slot = 1'b1;
                    unique case (q.st)
                        ST_ADDR: begin
                            if (q.shreg[7:1] == DEV_ADDR) begin
                                d.oe    = 1'b1;
                                d.rw    = q.shreg[0];
                                d.first = 1'b1;
                            end else begin
                                d.st       = ST_SKIP;
                                d.oe       = 1'b0;
                                d.ack_slot = 1'b0;
                            end
                        end
                        ST_WR: begin
                            d.oe = 1'b1;
                            if (q.first) begin
                                d.ptr   = q.shreg;
                                d.first = 1'b0;
                            end else begin
                                we_o  = 1'b1;
                                adv   = 1'b1;
                                d.ptr = next_ptr(q.ptr);
                            end
                        end
                        default: begin
                            d.oe   = 1'b0;
                            d.mack = 1'b0;
                            adv    = 1'b1;
                            d.ptr  = next_ptr(q.ptr);
                        end
                    endcase
                end else if (q.ack_slot) begin
                    d.ack_slot = 1'b0;
                    d.bitcnt   = 4'd0;
                    if (q.st == ST_ADDR) begin
                        if (q.rw) begin
                            d.st = ST_RD;
                            d.tx = rdata_i;
                            d.oe = ~rdata_i[7];
                        end else begin
                            d.st = ST_WR;
                            d.oe = 1'b0;
                        end
                    end else if (q.st == ST_WR) begin
                        d.oe = 1'b0;
                    end else if (q.mack) begin
                        d.tx = rdata_i;
                        d.oe = ~rdata_i[7];
                    end else begin
                        d.st = ST_SKIP;
                        d.oe = 1'b0;
                    end
                end else if (q.st == ST_RD) begin
                    d.oe = ~q.tx[3'd7 - q.bitcnt[2:0]];
                end
            end
        end else begin
            d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, bitcnt: 4'd0, ack_slot: 1'b0, shreg: 8'd0,
                   tx: 8'd0, ptr: 8'd0, rw: 1'b0, first: 1'b0, mack: 1'b0,
                   oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ptr_o    = q.ptr;
    assign sda_oe_o = q.oe;

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) && !$past(start_i) && !$past(stop_i) |-> !scl_lvl_i);

    // R1
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP) |-> !q.oe);

    // R3
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && q.ptr >= LAST) |=> (q.ptr == 8'd0));

    // R10
    start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q.st == ST_ADDR && q.bitcnt == 4'd0 && !q.ack_slot));

    // R6
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (q.st == ST_IDLE && !q.oe));

endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs #(
    parameter int                    NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0]   RO_MASK  = 8'h03,
    parameter logic [NUM_REGS-1:0]   RST_MASK = 8'hBF,
    parameter logic [NUM_REGS*8-1:0] RST_VAL  = 64'h77_00_55_44_33_21_0C_AC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [7:0]            waddr_i,
    input  logic [7:0]            wdata_i,
    input  logic [7:0]            raddr_i,
    output logic [7:0]            rdata_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (RO_MASK[i]) begin : g_ro
            assign regs_o[i*8 +: 8] = RST_VAL[i*8 +: 8];
        end else begin : g_rw
            logic [7:0] val_d, val_q;
            always_comb begin
                val_d = val_q;
                if (we_i && waddr_i == 8'(i)) begin
                    val_d = wdata_i;
                end
            end
            if (RST_MASK[i]) begin : g_rst
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) val_q <= RST_VAL[i*8 +: 8];
                    else        val_q <= val_d;
                end
            end else begin : g_norst
                always_ff @(posedge clk) begin
                    val_q <= val_d;
                end
            end
            assign regs_o[i*8 +: 8] = val_q;
        end
    end

    always_comb begin
        rdata_o = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (raddr_i == 8'(i)) rdata_o = regs_o[i*8 +: 8];
        end
    end

endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
    parameter logic [6:0]            DEV_ADDR    = 7'h2A,
    parameter int                    NUM_REGS    = 8,
    parameter int                    SYNC_STAGES = 2,
    parameter logic [NUM_REGS-1:0]   RO_MASK     = 8'h03,
    parameter logic [NUM_REGS-1:0]   RST_MASK    = 8'hBF,
    parameter logic [NUM_REGS*8-1:0] RST_VAL     = 64'h77_00_55_44_33_21_0C_AC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] ptr, rdata, wdata;
    logic       we;

    i2c_rb_lines #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_lvl_o  (scl_lvl),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_rb_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_lvl_i  (scl_lvl),
        .sda_lvl_i  (sda_lvl),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .rdata_i    (rdata),
        .ptr_o      (ptr),
        .we_o       (we),
        .wdata_o    (wdata),
        .sda_oe_o   (sda_oe_o)
    );

    i2c_rb_regs #(
        .NUM_REGS (NUM_REGS),
        .RO_MASK  (RO_MASK),
        .RST_MASK (RST_MASK),
        .RST_VAL  (RST_VAL)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (ptr),
        .wdata_i (wdata),
        .raddr_i (ptr),
        .rdata_o (rdata),
        .regs_o  (regs_o)
    );

endmodule

// File: tb/sim_i2c_regbank_target.sv
module sim_i2c_regbank_target;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 6;
    localparam logic [7:0] AW = 8'h54;
    localparam logic [7:0] AR = 8'h55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic        sda_line;
    logic [63:0] regs;
    int          checks = 0;
    int          fails = 0;
    int          viol = 0;
    logic        prev_oe = 1'b0;

    assign sda_line = ~(m_low | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regbank_target u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    // R11 monitor: drive changes seen while SCL is high
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && scl) viol++;
        prev_oe = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(QTR);
        scl = 1'b1;   tick(QTR);
        m_low = 1'b1; tick(QTR);
        scl = 1'b0;   tick(QTR);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(QTR);
        scl = 1'b1;   tick(QTR);
        m_low = 1'b0; tick(QTR);
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; tick(QTR);
        scl = 1'b1; tick(2*QTR);
        scl = 1'b0; tick(QTR);
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; tick(QTR);
        scl = 1'b1;   tick(QTR);
        b = sda_line; tick(QTR);
        scl = 1'b0;   tick(QTR);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~mack);
    endtask

    function automatic logic [7:0] reg_at(input int i);
        return regs[i*8 +: 8];
    endfunction

    task automatic t_reset();
        chk("R8", "reg0", reg_at(0), 8'hAC);
        chk("R8", "reg1", reg_at(1), 8'h0C);
        chk("R8", "reg2", reg_at(2), 8'h21);
        chk("R8", "reg3", reg_at(3), 8'h33);
        chk("R8", "reg4", reg_at(4), 8'h44);
        chk("R8", "reg5", reg_at(5), 8'h55);
        chk("R8", "reg7", reg_at(7), 8'h77);
        chk("R8", "sda_oe", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_current_read();
        logic a; logic [7:0] v;
        bus_start();
        write_byte(AR, a);
        chk("R1", "read addr ack", {7'd0, a}, 8'h01);
        read_byte(1'b0, v);
        chk("R4", "current read at reset ptr", v, 8'hAC);
        chk("R6", "released after NACK", {7'd0, sda_oe}, 8'h00);
        bus_stop(); tick(8);
        chk("R6", "released after STOP", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_burst_write();
        logic a;
        bus_start();
        write_byte(AW, a);   chk("R1", "write addr ack", {7'd0, a}, 8'h01);
        write_byte(8'h04, a); chk("R2", "subaddr ack", {7'd0, a}, 8'h01);
        write_byte(8'h5A, a); chk("R2", "data ack", {7'd0, a}, 8'h01);
        write_byte(8'h6B, a);
        write_byte(8'h7C, a);
        bus_stop(); tick(8);
        chk("R2", "reg4", reg_at(4), 8'h5A);
        chk("R2", "reg5", reg_at(5), 8'h6B);
        chk("R2", "reg6", reg_at(6), 8'h7C);
    endtask

    task automatic t_seq_read_wrap();
        logic a; logic [7:0] v;
        bus_start();
        write_byte(AR, a);
        read_byte(1'b1, v); chk("R3", "ptr advanced by writes", v, 8'h77);
        read_byte(1'b1, v); chk("R3", "wrap to 0", v, 8'hAC);
        read_byte(1'b0, v); chk("R6", "sequential third byte", v, 8'h0C);
        bus_stop(); tick(8);
    endtask

    task automatic t_random_read();
        logic a; logic [7:0] v;
        bus_start();
        write_byte(AW, a);
        write_byte(8'h05, a);
        bus_start();
        write_byte(AR, a);
        chk("R5", "restart addr ack", {7'd0, a}, 8'h01);
        read_byte(1'b1, v); chk("R5", "random read", v, 8'h6B);
        read_byte(1'b0, v); chk("R6", "next after ack", v, 8'h7C);
        bus_stop(); tick(8);
    endtask

    task automatic t_ro_write();
        logic a; logic [7:0] v;
        bus_start();
        write_byte(AW, a);
        write_byte(8'h00, a);
        write_byte(8'hFF, a); chk("R7", "ro write ack", {7'd0, a}, 8'h01);
        write_byte(8'hEE, a); chk("R7", "ro write ack 2", {7'd0, a}, 8'h01);
        bus_stop(); tick(8);
        chk("R7", "reg0 kept", reg_at(0), 8'hAC);
        chk("R7", "reg1 kept", reg_at(1), 8'h0C);
        bus_start();
        write_byte(AR, a);
        read_byte(1'b0, v); chk("R7", "ptr advanced past ro", v, 8'h21);
        bus_stop(); tick(8);
    endtask

    task automatic t_mismatch();
        logic a; logic [7:0] v;
        bus_start();
        write_byte(8'h60, a); chk("R1", "foreign addr nack", {7'd0, a}, 8'h00);
        write_byte(8'h05, a); chk("R1", "ignored byte nack", {7'd0, a}, 8'h00);
        write_byte(8'h99, a);
        bus_stop(); tick(8);
        chk("R1", "reg5 untouched", reg_at(5), 8'h6B);
        bus_start();
        write_byte(AR, a);
        read_byte(1'b0, v); chk("R1", "ptr untouched", v, 8'h33);
        bus_stop(); tick(8);
    endtask

    task automatic t_unimpl();
        logic a; logic [7:0] v;
        bus_start();
        write_byte(AW, a);
        write_byte(8'h20, a);
        write_byte(8'h99, a); chk("R9", "unimpl write ack", {7'd0, a}, 8'h01);
        bus_stop(); tick(8);
        chk("R9", "reg7 untouched", reg_at(7), 8'h77);
        bus_start();
        write_byte(AW, a);
        write_byte(8'h40, a);
        bus_start();
        write_byte(AR, a);
        read_byte(1'b0, v); chk("R9", "unimpl reads zero", v, 8'h00);
        bus_stop(); tick(8);
        bus_start();
        write_byte(AR, a);
        read_byte(1'b0, v); chk("R3", "wrap from beyond range", v, 8'hAC);
        bus_stop(); tick(8);
    endtask

    task automatic t_abort();
        logic a; logic [7:0] v;
        bus_start();
        write_byte(AW, a);
        write_byte(8'h03, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_stop(); tick(8);
        chk("R10", "stop drops partial byte", reg_at(3), 8'h33);
        bus_start();
        write_byte(AR, a);
        read_byte(1'b0, v); chk("R10", "ptr after stop abort", v, 8'h33);
        bus_stop(); tick(8);
        bus_start();
        write_byte(AW, a);
        write_byte(8'h02, a);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_start();
        write_byte(AR, a);
        chk("R10", "addr after start abort", {7'd0, a}, 8'h01);
        read_byte(1'b0, v); chk("R10", "ptr after start abort", v, 8'h21);
        bus_stop(); tick(8);
        chk("R10", "reg2 unchanged", reg_at(2), 8'h21);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_current_read();
        t_burst_write();
        t_seq_read_wrap();
        t_random_read();
        t_ro_write();
        t_mismatch();
        t_unimpl();
        t_abort();
        chk("R11", "drive changes while SCL high", 8'(viol), 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule